// File: doc/BRIEF.md
# Reloadable Baud Tick Generator

This block derives a 16x oversampling tick for a serial channel from the module clock. A 13-bit reload down-counter sets the tick period. The counter steps on an enable that comes from one of two pre-dividers. The first is a fixed prescaler that divides the clock by 2 or 3. The second is a fractional phase accumulator that adds a programmable increment every clock and fires each time its sum passes 8192.

Software loads the reload value and the fractional increment, selects a mode, and then raises the run bit. The reload register is locked while the block runs. Dropping the run bit silences the output and returns every counter to its starting state, so the next run begins with a full first period.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and whenever run_en is low, tick stays 0. The reload value and the fractional increment both reset to 0.
- R2: With frac_en=0 and pre_sel=0, the first tick comes in run cycle 2*(R+1)-1, where R is the reload value and run cycle 0 is the first cycle with run_en high. Later ticks follow every 2*(R+1) cycles.
- R3: With frac_en=0 and pre_sel=1, the first tick comes in run cycle 3*(R+1)-1, and later ticks follow every 3*(R+1) cycles.
- R4: In integer mode, tick is high for a single clock per period and is never high in two consecutive cycles.
- R5: With frac_en=1 and increment F, the accumulator starts at 0 and adds F every run cycle. Each carry past 8192 steps the reload counter. Over 8192*(R+1) run cycles, exactly F ticks occur. F=0 gives no ticks.
- R6: The increment is written from fdv_wdata[12:0]. Bits 15:13 are masked off and have no effect on the tick rate.
- R7: A reload write (reload_we) takes effect only while run_en is low. A write made while running changes neither the current nor the next run's period.
- R8: Clearing run_en stops tick on the same cycle. It also clears the prescaler, the accumulator and the reload counter, so a restart after a partial period begins with a full first period.
- R9: Every reload value from 0 to 8191 is accepted. At R=8191 with the divide-by-2 prescaler, the first tick comes in run cycle 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run bit; low stops and clears the generator |
| pre_sel | input | 1 | Prescaler select: 0 divides by 2, 1 divides by 3 |
| frac_en | input | 1 | 1 selects the fractional accumulator instead of the prescaler |
| fdv_we | input | 1 | Write strobe for the fractional increment |
| fdv_wdata | input | 16 | Increment write data; only the low 13 bits are kept |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_wdata | input | 13 | Reload value |
| tick | output | 1 | Single-cycle oversampling tick |

## Verification
The tick output is a combinational decode of registered state and run_en, so a tick belongs to the cycle in which it is visible. The bench counts run cycles from the first cycle with run_en high. It drives inputs on the falling edge and samples tick 1 ns later in the same cycle. Expected first-tick cycles are P*(R+1)-1 in integer mode and follow the carry pattern in fractional mode. These are compared directly, together with the gaps between ticks and the tick counts over windows of known length. Register writes land on the rising edge after the strobe, so each write sits in a cycle before the run starts, or, for the locking case, inside a running window.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int RELOAD_W = 13;
  localparam int FRAC_W   = 13;
  localparam int BUS_W    = 16;

  // last prescaler count before an enable: 1 for divide-by-2, 2 for divide-by-3
  function automatic logic [1:0] pre_last(input logic sel);
    return sel ? 2'd2 : 2'd1;
  endfunction

  // next prescaler count, wrapping at the selected limit
  function automatic logic [1:0] pre_next(input logic [1:0] cnt, input logic sel);
    return (cnt >= pre_last(sel)) ? 2'd0 : cnt + 2'd1;
  endfunction

  // keep only the increment field of a bus word
  function automatic logic [BUS_W-1:0] frac_mask(input logic [BUS_W-1:0] w);
    logic [BUS_W-1:0] m;
    m = '0;
    m[FRAC_W-1:0] = '1;
    return w & m;
  endfunction

endpackage

// File: rtl/bg_prescale.sv
module bg_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel,
  output logic en_o
);
  import baud_pkg::*;

  logic [1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pcnt_q <= '0;
    else if (!run) pcnt_q <= '0;
    else          pcnt_q <= pre_next(pcnt_q, sel);
  end

  assign en_o = run && (pcnt_q >= pre_last(sel));

  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> !en_o); // R4
  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcnt_q == 2'd0); // R8

endmodule

// File: rtl/bg_frac_accum.sv
module bg_frac_accum #(
  parameter int FW = baud_pkg::FRAC_W,
  parameter int BW = baud_pkg::BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fdv_we,
  input  logic [BW-1:0] fdv_wdata,
  output logic          pulse_o
);
  import baud_pkg::*;

  logic [BW-1:0] fdv_q;
  logic [FW-1:0] acc_q;
  logic [BW:0]   sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fdv_q <= '0;
    else if (fdv_we) fdv_q <= frac_mask(fdv_wdata);
  end

  assign sum = {{(BW+1-FW){1'b0}}, acc_q} + {1'b0, fdv_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (!run) acc_q <= '0;
    else           acc_q <= sum[FW-1:0];
  end

  assign pulse_o = run && (sum[BW:FW] != '0);

  AST_FDV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    fdv_we |=> fdv_q[BW-1:FW] == '0); // R6
  AST_ACC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> {{(BW-FW){1'b0}}, acc_q} < $past(fdv_q)); // R5
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> acc_q == '0); // R8

endmodule

// File: rtl/bg_reload_cnt.sv
module bg_reload_cnt #(
  parameter int CW = baud_pkg::RELOAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic          tick_o
);
  logic [CW-1:0] reload_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok;
  logic          at_zero;

  assign wr_ok   = we && !run;
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reload_q <= '0;
    else if (wr_ok) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= wr_ok ? wdata : reload_q;
    else if (step)    cnt_q <= at_zero ? reload_q : cnt_q - 1'b1;
  end

  assign tick_o = run && step && at_zero;

  AST_RELOAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && we) |=> $stable(reload_q)); // R7
  AST_RUN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick_o); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= reload_q); // R9
  AST_RELOAD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == $past(reload_q)); // R2

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CW = baud_pkg::RELOAD_W,
  parameter int FW = baud_pkg::FRAC_W,
  parameter int BW = baud_pkg::BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          pre_sel,
  input  logic          frac_en,
  input  logic          fdv_we,
  input  logic [BW-1:0] fdv_wdata,
  input  logic          reload_we,
  input  logic [CW-1:0] reload_wdata,
  output logic          tick
);
  logic pre_pulse;
  logic frac_pulse;
  logic step;

  bg_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_en),
    .sel   (pre_sel),
    .en_o  (pre_pulse)
  );

  bg_frac_accum #(.FW(FW), .BW(BW)) u_frac (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .fdv_we    (fdv_we),
    .fdv_wdata (fdv_wdata),
    .pulse_o   (frac_pulse)
  );

  assign step = frac_en ? frac_pulse : pre_pulse;

  bg_reload_cnt #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_en),
    .step   (step),
    .we     (reload_we),
    .wdata  (reload_wdata),
    .tick_o (tick)
  );

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frac_en) |=> !(tick && !frac_en)); // R4
  AST_TICK_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> step); // R2

endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        pre_sel = 1'b0;
  logic        frac_en = 1'b0;
  logic        fdv_we = 1'b0;
  logic [15:0] fdv_wdata = '0;
  logic        reload_we = 1'b0;
  logic [12:0] reload_wdata = '0;
  logic        tick;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_sel(pre_sel),
    .frac_en(frac_en), .fdv_we(fdv_we), .fdv_wdata(fdv_wdata),
    .reload_we(reload_we), .reload_wdata(reload_wdata), .tick(tick)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge with run_en low
  task automatic wr_reload(input int v);
    reload_wdata = 13'(v);
    reload_we = 1'b1;
    @(negedge clk);
    reload_we = 1'b0;
  endtask

  task automatic wr_fdv(input int v);
    fdv_wdata = 16'(v);
    fdv_we = 1'b1;
    @(negedge clk);
    fdv_we = 1'b0;
  endtask

  // raises run_en at the current falling edge, samples n run cycles;
  // optional reload write of value 0 during cycle wr_at
  task automatic run_measure(input int n, input int wr_at,
                             output int first, output int cnt, output int min_gap, output int max_gap);
    int last;
    first = -1; cnt = 0; min_gap = 1 << 30; max_gap = 0; last = -1;
    run_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i == wr_at) begin reload_wdata = '0; reload_we = 1'b1; end
      else reload_we = 1'b0;
      #1;
      if (tick) begin
        if (first < 0) first = i;
        if (last >= 0) begin
          if (i - last < min_gap) min_gap = i - last;
          if (i - last > max_gap) max_gap = i - last;
        end
        last = i;
        cnt++;
      end
      @(negedge clk);
    end
    reload_we = 1'b0;
  endtask

  task automatic stop_run();
    run_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int i = 0; i < 20; i++) begin
      #1; if (tick) seen++;
      @(negedge clk);
    end
    check("R1", "ticks while idle after reset", seen, 0);
    frac_en = 1'b1;
    begin
      int f, c, mn, mx;
      run_measure(100, -1, f, c, mn, mx);
      check("R1", "reset increment gives no ticks", c, 0);
      stop_run();
    end
    frac_en = 1'b0;
  endtask

  task automatic t_div2();
    int f, c, mn, mx;
    pre_sel = 1'b0; wr_reload(4);
    run_measure(100, -1, f, c, mn, mx);
    check("R2", "first tick div2 R=4", f, 9);
    check("R2", "tick count div2 R=4", c, 10);
    check("R2", "period div2 R=4", mx, 10);
    check("R2", "min period div2 R=4", mn, 10);
    stop_run();
  endtask

  task automatic t_div3();
    int f, c, mn, mx;
    pre_sel = 1'b1; wr_reload(2);
    run_measure(90, -1, f, c, mn, mx);
    check("R3", "first tick div3 R=2", f, 8);
    check("R3", "tick count div3 R=2", c, 10);
    check("R3", "period div3 R=2", mx, 9);
    stop_run();
    pre_sel = 1'b0;
  endtask

  task automatic t_pulse();
    int f, c, mn, mx;
    pre_sel = 1'b0; wr_reload(0);
    run_measure(40, -1, f, c, mn, mx);
    check("R4", "first tick R=0", f, 1);
    check("R4", "tick count R=0", c, 20);
    check("R4", "minimum gap R=0", mn, 2);
    stop_run();
  endtask

  task automatic t_frac();
    int f, c, mn, mx;
    frac_en = 1'b1;
    wr_fdv(3000); wr_reload(0);
    run_measure(8192, -1, f, c, mn, mx);
    check("R5", "ticks over 8192 cycles F=3000", c, 3000);
    stop_run();
    wr_fdv(4096); wr_reload(1);
    run_measure(400, -1, f, c, mn, mx);
    check("R5", "first tick F=4096 R=1", f, 3);
    check("R5", "tick count F=4096 R=1", c, 100);
    stop_run();
    wr_fdv(0);
    run_measure(200, -1, f, c, mn, mx);
    check("R5", "no ticks with F=0", c, 0);
    stop_run();
    frac_en = 1'b0;
  endtask

  task automatic t_mask();
    int f, c, mn, mx;
    frac_en = 1'b1;
    wr_fdv(16'hE000 | 1024); wr_reload(0);
    run_measure(80, -1, f, c, mn, mx);
    check("R6", "first tick with masked high bits", f, 7);
    check("R6", "tick count with masked high bits", c, 10);
    stop_run();
    frac_en = 1'b0;
  endtask

  task automatic t_lock();
    int f, c, mn, mx;
    pre_sel = 1'b0; wr_reload(3);
    run_measure(80, 2, f, c, mn, mx);
    check("R7", "first tick after write while running", f, 7);
    check("R7", "tick count after write while running", c, 10);
    stop_run();
    run_measure(40, -1, f, c, mn, mx);
    check("R7", "restart keeps locked reload", f, 7);
    stop_run();
  endtask

  task automatic t_stop();
    int f, c, mn, mx, seen;
    pre_sel = 1'b0; wr_reload(1);
    run_measure(6, -1, f, c, mn, mx);
    check("R8", "tick before stop", f, 3);
    run_en = 1'b0;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      #1; if (tick) seen++;
      @(negedge clk);
    end
    check("R8", "ticks while stopped", seen, 0);
    run_measure(20, -1, f, c, mn, mx);
    check("R8", "first tick after restart", f, 3);
    stop_run();
  endtask

  task automatic t_max();
    int f, c, mn, mx;
    pre_sel = 1'b0; wr_reload(8191);
    run_measure(16400, -1, f, c, mn, mx);
    check("R9", "first tick at R=8191", f, 16383);
    check("R9", "tick count at R=8191", c, 1);
    stop_run();
  endtask

  initial begin
    #200000ns;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_div2();
    t_div3();
    t_pulse();
    t_frac();
    t_mask();
    t_lock();
    t_stop();
    t_max();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule